// File: doc/BRIEF.md
# Protected-Configuration Watchdog Timer

This block is a watchdog timer that counts ticks from a slow enable, `tick_i`. The enable stands in for a separate low-frequency oscillator, nominally 1 MHz, while all registers run on the system clock. A 3-bit tap select picks one of eight time-out lengths. If software does not kick the watchdog before the selected length has passed, the block raises a one-cycle system reset pulse, so that the processor restarts from its reset vector. A sticky flag records that the last reset came from the watchdog.

A static strap, `safe_lvl2_i`, sets the protection level. At level 1 the watchdog leaves reset disabled, and software may switch it on at any time. Switching it off or changing the tap is only accepted in a short unlock window. At level 2 the watchdog is on from reset and cannot be switched off. Even at level 2, a tap change still needs the unlock window. Software opens the window with a write that sets both the change bit and the enable bit. The next write, if it comes within `WIN_CYC` system clocks, is the protected update.

Top module: `wdt_guard`

## Requirements
- R1: After rst_ni is released, tap_sel_o is 0, unlock_o is 0, wd_rst_o is 0 and wd_flag_o is 0. enabled_o is 0 at level 1 and 1 at level 2.
- R2: With tap select n, the time-out fires on the 2^(BASE_EXP+n)-th tick after the tick that applied the last clear. A time-out also clears the counter.
- R3: The counter advances only in cycles where tick_i is high. A time-out measured in ticks does not depend on the spacing between ticks.
- R4: A kick clears the counter on the next tick. If no tick is present when the kick arrives, the kick is held until a tick comes.
- R5: wd_rst_o goes high for exactly one system clock, in the cycle after the clock edge on which the expiring tick was taken.
- R6: At level 1, a control write with wr_data_i[3] (enable) set and wr_data_i[4] (change) clear, made outside the window, turns the watchdog on and leaves the tap select unchanged.
- R7: A write with both wr_data_i[4] and wr_data_i[3] set opens a window, shown on unlock_o, for the next WIN_CYC cycles. The first write in the window loads enable from wr_data_i[3] and the tap from wr_data_i[2:0], and then closes the window.
- R8: Outside the window, a write with enable clear does not switch the watchdog off, and a write does not change the tap select.
- R9: At level 2, enabled_o stays 1 whatever is written, including inside the window. A tap change still needs the window.
- R10: Switching the watchdog off clears the counter. While the watchdog is off, no reset pulse is produced.
- R11: wd_flag_o is set whenever a watchdog reset is produced. A flag write of 0 clears it and a flag write of 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow watchdog tick enable |
| safe_lvl2_i | input | 1 | Static strap: 1 selects level 2 (forced on) |
| kick_i | input | 1 | Watchdog kick (counter clear) |
| wr_i | input | 1 | Control register write strobe |
| wr_data_i | input | 5 | [4] change, [3] enable, [2:0] tap select |
| flag_wr_i | input | 1 | Reset-flag write strobe |
| flag_data_i | input | 1 | Reset-flag write value (0 clears) |
| wd_rst_o | output | 1 | One-cycle system reset pulse |
| enabled_o | output | 1 | Watchdog running |
| tap_sel_o | output | 3 | Current tap select |
| unlock_o | output | 1 | Protected-write window open |
| wd_flag_o | output | 1 | Last reset came from the watchdog |

## Verification
The bench sets BASE_EXP to 2, which shrinks the eight time-outs to 4 to 512 ticks. At that size every tap can be measured to its exact tick count, both with back-to-back ticks and with spaced ticks. WIN_CYC keeps its default of 4. The bench probes the window at its last accepted slot and at the first rejected slot. It also resets the block under both strap values, so the forced-on level and the protected tap changes are checked on one instance.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int N_TAPS = 8;
  localparam int PSEL_W = $clog2(N_TAPS);
  localparam int CTL_W  = PSEL_W + 2;

  typedef struct packed {
    logic              chg;
    logic              ena;
    logic [PSEL_W-1:0] psel;
  } wdt_ctl_t;
endpackage

// File: rtl/wdt_cfg_lock.sv
module wdt_cfg_lock
  import wdt_pkg::*;
#(
  parameter int WIN_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lvl2_i,
  input  logic              wr_i,
  input  wdt_ctl_t          wr_ctl_i,
  output logic              ena_o,
  output logic [PSEL_W-1:0] psel_o,
  output logic              open_o
);
  localparam int WIN_W = $clog2(WIN_CYC + 1);

  logic [WIN_W-1:0]  win_q;
  logic              ena_q;
  logic [PSEL_W-1:0] psel_q;
  logic              win_open;

  assign win_open = (win_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      ena_q  <= 1'b0;
      psel_q <= '0;
    end else if (wr_i) begin
      if (win_open) begin
        ena_q  <= wr_ctl_i.ena;
        psel_q <= wr_ctl_i.psel;
        win_q  <= '0;
      end else begin
        // enabling is never locked; the unlock pattern also enables
        if (wr_ctl_i.ena) ena_q <= 1'b1;
        if (wr_ctl_i.chg && wr_ctl_i.ena) win_q <= WIN_W'(WIN_CYC);
      end
    end else if (win_open) begin
      win_q <= win_q - 1'b1;
    end
  end

  assign ena_o  = ena_q | lvl2_i;
  assign psel_o = psel_q;
  assign open_o = win_open;
endmodule

// File: rtl/wdt_tap_counter.sv
module wdt_tap_counter
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ena_i,
  input  logic              kick_i,
  input  logic [PSEL_W-1:0] psel_i,
  output logic              expire_o
);
  localparam int CNT_W = BASE_EXP + N_TAPS - 1;

  logic [CNT_W-1:0] lim_tab [N_TAPS];
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             clr;

  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    assign lim_tab[g] = CNT_W'((64'd1 << (BASE_EXP + g)) - 64'd1);
  end

  assign clr      = pend_q | kick_i;
  assign expire_o = ena_i & tick_i & ~clr & (cnt_q >= lim_tab[psel_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (!ena_i) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (tick_i) begin
      pend_q <= 1'b0;
      if (clr || expire_o) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
    end else if (kick_i) begin
      pend_q <= 1'b1;  // hold kick until the next tick
    end
  end
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic flag_wr_i,
  input  logic flag_data_i,
  output logic rst_o,
  output logic flag_o
);
  logic rst_q;
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      rst_q <= expire_i;
      if (expire_i || rst_q)             flag_q <= 1'b1;
      else if (flag_wr_i && !flag_data_i) flag_q <= 1'b0;
    end
  end

  assign rst_o  = rst_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 11,
  parameter int WIN_CYC  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              safe_lvl2_i,
  input  logic              kick_i,
  input  logic              wr_i,
  input  logic [CTL_W-1:0]  wr_data_i,
  input  logic              flag_wr_i,
  input  logic              flag_data_i,
  output logic              wd_rst_o,
  output logic              enabled_o,
  output logic [PSEL_W-1:0] tap_sel_o,
  output logic              unlock_o,
  output logic              wd_flag_o
);
  logic              ena;
  logic [PSEL_W-1:0] psel;
  logic              expire;

  wdt_cfg_lock #(.WIN_CYC(WIN_CYC)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl2_i   (safe_lvl2_i),
    .wr_i     (wr_i),
    .wr_ctl_i (wdt_ctl_t'(wr_data_i)),
    .ena_o    (ena),
    .psel_o   (psel),
    .open_o   (unlock_o)
  );

  wdt_tap_counter #(.BASE_EXP(BASE_EXP)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .ena_i    (ena),
    .kick_i   (kick_i),
    .psel_i   (psel),
    .expire_o (expire)
  );

  wdt_rst_pulse u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .expire_i    (expire),
    .flag_wr_i   (flag_wr_i),
    .flag_data_i (flag_data_i),
    .rst_o       (wd_rst_o),
    .flag_o      (wd_flag_o)
  );

  assign enabled_o = ena;
  assign tap_sel_o = psel;
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int WIN_CYC = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       safe_lvl2_i,
  input logic       wr_i,
  input logic       wd_rst_o,
  input logic       enabled_o,
  input logic [2:0] tap_sel_o,
  input logic       unlock_o,
  input logic       wd_flag_o
);
  logic [7:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= '0;
    else if (unlock_o) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  p_pulse_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_rst_o |=> !wd_rst_o);

  p_rst_after_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_rst_o |-> $past(tick_i));

  p_flag_on_rst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_rst_o |-> wd_flag_o);

  p_forced_on_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    safe_lvl2_i |-> enabled_o);

  p_quiet_when_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enabled_o |=> !wd_rst_o);

  p_tap_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !unlock_o) |=> (tap_sel_o == $past(tap_sel_o)));

  p_window_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_o |-> (int'(run_q) < WIN_CYC));
endmodule

bind wdt_guard wdt_guard_chk #(.WIN_CYC(WIN_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .safe_lvl2_i (safe_lvl2_i),
  .wr_i        (wr_i),
  .wd_rst_o    (wd_rst_o),
  .enabled_o   (enabled_o),
  .tap_sel_o   (tap_sel_o),
  .unlock_o    (unlock_o),
  .wd_flag_o   (wd_flag_o)
);

// File: tb/wdt_guard_test.sv
module wdt_guard_test;
  localparam int BASE = 2;
  // expected ticks counted from the kicking tick through the expiring tick
  localparam int EXP_TICKS [8] = '{5, 9, 17, 33, 65, 129, 257, 513};

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b1, safe_lvl2_i = 1'b0;
  logic kick_i = 1'b0, wr_i = 1'b0, flag_wr_i = 1'b0, flag_data_i = 1'b0;
  logic [4:0] wr_data_i = '0;
  logic wd_rst_o, enabled_o, unlock_o, wd_flag_o;
  logic [2:0] tap_sel_o;
  int n_chk = 0, n_bad = 0;

  always #10 clk_i = ~clk_i;

  wdt_guard #(.BASE_EXP(BASE), .WIN_CYC(4)) uut (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr_ctl(input logic chg, input logic ena, input logic [2:0] ps);
    wr_i = 1'b1; wr_data_i = {chg, ena, ps};
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic do_reset(input logic lvl2);
    rst_ni = 1'b0; safe_lvl2_i = lvl2; tick_i = 1'b1;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
  endtask

  task automatic measure(input int gap, output int ticks, output int cycles,
                         output int pulse_one);
    kick_i = 1'b1; tick_i = 1'b1; ticks = 0; cycles = 0;
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk_i);
      cycles++;
      if (tick_i) ticks++;
      @(negedge clk_i);
      kick_i = 1'b0;
      tick_i = ((i + 1) % gap == 0);
      if (wd_rst_o) break;
    end
    @(negedge clk_i);
    pulse_one = !wd_rst_o;
    tick_i = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int t, c, p, hits;
    do_reset(1'b0);
    check("R1 enabled", enabled_o, 0);
    check("R1 tap", tap_sel_o, 0);
    check("R1 unlock", unlock_o, 0);
    check("R1 rst", wd_rst_o, 0);
    check("R1 flag", wd_flag_o, 0);

    // table walk over all taps
    for (int n = 0; n < 8; n++) begin
      wr_ctl(1'b1, 1'b1, 3'd0);
      wr_ctl(1'b0, 1'b1, 3'(n));
      check("R7 tap load", tap_sel_o, n);
      measure(1, t, c, p);
      check("R2 ticks to time-out", t, EXP_TICKS[n]);
      check("R5 single pulse", p, 1);
    end
    check("R11 flag set", wd_flag_o, 1);
    flag_wr_i = 1'b1; flag_data_i = 1'b1; idle(1); flag_wr_i = 1'b0;
    check("R11 write 1 ignored", wd_flag_o, 1);
    flag_wr_i = 1'b1; flag_data_i = 1'b0; idle(1); flag_wr_i = 1'b0;
    check("R11 write 0 clears", wd_flag_o, 0);

    // spaced ticks, tap 1
    wr_ctl(1'b1, 1'b1, 3'd0);
    wr_ctl(1'b0, 1'b1, 3'd1);
    measure(3, t, c, p);
    check("R3 ticks spaced", t, 9);
    check("R3 cycles spaced", c, 25);

    // regular kicks keep it quiet, tap 0
    wr_ctl(1'b1, 1'b1, 3'd0);
    wr_ctl(1'b0, 1'b1, 3'd0);
    hits = 0;
    for (int k = 0; k < 30; k++) begin
      kick_i = 1'b1; idle(1); kick_i = 1'b0;
      if (wd_rst_o) hits++;
      idle(1); if (wd_rst_o) hits++;
      idle(1); if (wd_rst_o) hits++;
    end
    check("R4 kicks prevent reset", hits, 0);

    // kick without a tick is held
    kick_i = 1'b1; idle(1); kick_i = 1'b0; idle(1);
    tick_i = 1'b0; kick_i = 1'b1; idle(1); kick_i = 1'b0; idle(2);
    tick_i = 1'b1; t = 0;
    for (int i = 0; i < 50; i++) begin
      @(posedge clk_i); t++;
      @(negedge clk_i);
      if (wd_rst_o) break;
    end
    check("R4 held kick", t, 5);

    // window behaviour
    do_reset(1'b0);
    wr_ctl(1'b1, 1'b1, 3'd0);
    hits = 0;
    for (int i = 0; i < 6; i++) begin
      if (unlock_o) hits++;
      idle(1);
    end
    check("R7 window length", hits, 4);
    check("R6 unlock enables", enabled_o, 1);
    wr_ctl(1'b0, 1'b0, 3'd5);
    check("R8 disable ignored", enabled_o, 1);
    check("R8 tap ignored", tap_sel_o, 0);
    wr_ctl(1'b1, 1'b1, 3'd0); idle(3);
    wr_ctl(1'b0, 1'b1, 3'd6);
    check("R7 last slot accepted", tap_sel_o, 6);
    wr_ctl(1'b1, 1'b1, 3'd0); idle(4);
    wr_ctl(1'b0, 1'b1, 3'd2);
    check("R8 late write ignored", tap_sel_o, 6);
    wr_ctl(1'b1, 1'b1, 3'd0);
    wr_ctl(1'b0, 1'b1, 3'd1);
    wr_ctl(1'b0, 1'b1, 3'd4);
    check("R7 single write per window", tap_sel_o, 1);
    wr_ctl(1'b1, 1'b1, 3'd0);
    wr_ctl(1'b0, 1'b0, 3'd3);
    check("R7 disable in window", enabled_o, 0);
    check("R7 tap in window", tap_sel_o, 3);
    check("R7 window closed", unlock_o, 0);
    wr_ctl(1'b0, 1'b1, 3'd7);
    check("R6 plain enable", enabled_o, 1);
    check("R6 tap unchanged", tap_sel_o, 3);

    // disable clears counter, and off means quiet
    wr_ctl(1'b1, 1'b1, 3'd0);
    wr_ctl(1'b0, 1'b1, 3'd0);
    kick_i = 1'b1; idle(1); kick_i = 1'b0; idle(2);
    wr_ctl(1'b1, 1'b1, 3'd0);
    wr_ctl(1'b0, 1'b0, 3'd0);
    wr_ctl(1'b0, 1'b1, 3'd0);
    t = 0;
    for (int i = 0; i < 50; i++) begin
      @(posedge clk_i); t++;
      @(negedge clk_i);
      if (wd_rst_o) break;
    end
    check("R10 cleared on disable", t, 4);
    wr_ctl(1'b1, 1'b1, 3'd0);
    wr_ctl(1'b0, 1'b0, 3'd0);
    hits = 0;
    for (int i = 0; i < 600; i++) begin
      idle(1);
      if (wd_rst_o) hits++;
    end
    check("R10 no reset while off", hits, 0);

    // level 2
    do_reset(1'b1);
    check("R1 level2 enabled", enabled_o, 1);
    wr_ctl(1'b0, 1'b0, 3'd5);
    check("R9 disable ignored", enabled_o, 1);
    check("R9 tap needs window", tap_sel_o, 0);
    wr_ctl(1'b1, 1'b1, 3'd0);
    wr_ctl(1'b0, 1'b0, 3'd5);
    check("R9 stays on in window", enabled_o, 1);
    check("R9 tap via window", tap_sel_o, 5);
    measure(1, t, c, p);
    check("R9 time-out at level2", t, EXP_TICKS[5]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule